// File: doc/BRIEF.md
# Task Priority Gate

This block is the acceptance stage that sits between a local interrupt source and a processor core. It keeps an 8-bit task priority, compares the priority class of the highest pending vector against it, and raises a request to the core when that class is higher than both the task priority and any vector already in service. When the core acknowledges, the gate checks the mask again against the priority at that moment. If the pending vector has been masked in the meantime, the gate returns a programmable spurious vector instead of the pending one.

Software can set the task priority in two ways. A byte-wide direct register port writes all eight bits. A narrow control-register view carries only the upper priority nibble in its low four bits, and every other bit of that view is reserved. The direct port also programs the spurious vector and a controller-enable bit. In-service tracking holds a single vector. A real acknowledge sets it and an end-of-interrupt pulse clears it.

Top module: `prio_gate`

## Requirements
- R1: After a synchronous reset, the task priority is 0x00, the spurious vector is 0xFF, the controller is enabled, and irq, ack_valid, ack_spur, cr_fault and isr_active are all 0.
- R2: A direct write (mm_we=1) uses mm_sel to choose its target: 0 loads all 8 priority bits, 1 loads the spurious vector, and 2 loads the enable bit from mm_wdata bit 0. Each takes effect at the next clock edge.
- R3: While the controller is enabled, a control-register write whose bits above bit 3 are all zero sets priority [7:4] to cr_wdata[3:0] and clears priority [3:0].
- R4: A control-register write with any nonzero bit above bit 3 raises cr_fault for exactly the one cycle after the write and leaves the priority unchanged.
- R5: cr_rdata returns priority [7:4] zero-extended to the full width while the controller is enabled. While it is disabled, cr_rdata reads 0 and control-register writes leave the priority unchanged.
- R6: When a direct priority write and a control-register write happen in the same cycle, the direct 8-bit value is the one kept.
- R7: In the cycle after the inputs are presented, irq is 1 exactly when pend_valid is 1, pend_vec[7:4] is strictly greater than priority [7:4], and either no vector is in service or pend_vec[7:4] is greater than the class of the in-service vector.
- R8: A one-cycle ack pulse produces ack_valid for one cycle in the next cycle. If, at the ack edge, pend_valid is 1 and pend_vec[7:4] is greater than priority [7:4], ack_vec is pend_vec and ack_spur is 0. Otherwise ack_vec is the spurious vector and ack_spur is 1.
- R9: A non-spurious acknowledge makes isr_active 1 and isr_vec equal to the acknowledged vector, and drives irq to 0 in the same cycle that ack_valid is 1.
- R10: A spurious acknowledge leaves isr_active and isr_vec unchanged.
- R11: An eoi pulse clears isr_active at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mm_we | input | 1 | Direct register write strobe |
| mm_sel | input | 2 | Direct write target: 0 priority, 1 spurious vector, 2 enable |
| mm_wdata | input | 8 | Direct write data |
| cr_we | input | 1 | Control-register view write strobe |
| cr_wdata | input | CRW (64) | Control-register view write data |
| cr_rdata | output | CRW (64) | Control-register view read data |
| cr_fault | output | 1 | One-cycle pulse for a write with reserved bits set |
| prio_o | output | 8 | Current task priority |
| spur_o | output | 8 | Current spurious vector |
| en_o | output | 1 | Controller enable |
| pend_valid | input | 1 | A pending vector is present |
| pend_vec | input | 8 | Highest pending vector |
| ack | input | 1 | Acknowledge pulse from the core |
| eoi | input | 1 | End-of-interrupt pulse |
| irq | output | 1 | Interrupt request to the core |
| ack_valid | output | 1 | Acknowledge result strobe |
| ack_vec | output | 8 | Vector returned on acknowledge |
| ack_spur | output | 1 | Returned vector is the spurious one |
| isr_active | output | 1 | A vector is in service |
| isr_vec | output | 8 | In-service vector |

## Verification
The hardest case to reach is a request that is already raised and then masked before the core acknowledges it. The bench first gets irq to 1 with an eligible pending vector. It then raises the priority through the control-register view, and on the following cycle it pulses ack. It expects the spurious vector back, with the in-service state left as it was. A second variant masks the vector with a direct write while a vector is already in service. The bench then confirms that the earlier isr_vec survives the spurious acknowledge.

// File: rtl/gate_pkg.sv
package gate_pkg;
  localparam int VW = 8;
  localparam int CW = 4;
  typedef enum logic [1:0] {
    SEL_PRIO = 2'd0,
    SEL_SPUR = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } mm_sel_e;
endpackage

// File: rtl/tpr_reg.sv
module tpr_reg
  import gate_pkg::*;
#(
  parameter int CRW = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mm_we,
  input  logic [1:0]     mm_sel,
  input  logic [VW-1:0]  mm_wdata,
  input  logic           cr_we,
  input  logic [CRW-1:0] cr_wdata,
  output logic [VW-1:0]  prio_q,
  output logic [VW-1:0]  spur_q,
  output logic           en_q,
  output logic           fault_q,
  output logic [CRW-1:0] cr_rdata
);
  localparam int RSV = CRW - CW;

  logic mm_prio_we, cr_bad, cr_take;

  assign mm_prio_we = mm_we && (mm_sel == SEL_PRIO);
  assign cr_bad     = |cr_wdata[CRW-1:CW];
  assign cr_take    = cr_we && !cr_bad && en_q && !mm_prio_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q  <= '0;
      spur_q  <= '1;
      en_q    <= 1'b1;
      fault_q <= 1'b0;
    end else begin
      fault_q <= cr_we && cr_bad;
      if (mm_prio_we)
        prio_q <= mm_wdata;
      else if (cr_take)
        prio_q <= {cr_wdata[CW-1:0], {(VW-CW){1'b0}}};
      if (mm_we && (mm_sel == SEL_SPUR))
        spur_q <= mm_wdata;
      if (mm_we && (mm_sel == SEL_CTRL))
        en_q <= mm_wdata[0];
    end
  end

  assign cr_rdata = en_q ? {{RSV{1'b0}}, prio_q[VW-1:VW-CW]} : '0;

  assert_fault_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (cr_we && cr_bad && !mm_prio_we) |=> ($stable(prio_q) && fault_q));

  assert_cr_low_zero_R3: assert property (@(posedge clk) disable iff (rst)
    cr_take |=> (prio_q[VW-CW-1:0] == '0));

  assert_disabled_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (cr_we && !en_q && !mm_prio_we) |=> $stable(prio_q));
endmodule

// File: rtl/req_eval.sv
module req_eval
  import gate_pkg::*;
(
  input  logic          pend_valid,
  input  logic [CW-1:0] pend_cls,
  input  logic [CW-1:0] prio_cls,
  input  logic          isr_active,
  input  logic [CW-1:0] isr_cls,
  output logic          above_prio,
  output logic          eligible
);
  always_comb begin
    above_prio = pend_valid && (pend_cls > prio_cls);
    eligible   = above_prio && (!isr_active || (pend_cls > isr_cls));
  end
endmodule

// File: rtl/ack_unit.sv
module ack_unit
  import gate_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          ack,
  input  logic          eoi,
  input  logic          above_prio,
  input  logic          eligible,
  input  logic [VW-1:0] pend_vec,
  input  logic [VW-1:0] spur_vec,
  output logic          irq_q,
  output logic          ack_valid_q,
  output logic [VW-1:0] ack_vec_q,
  output logic          ack_spur_q,
  output logic          isr_active_q,
  output logic [VW-1:0] isr_vec_q
);
  logic real_ack;

  assign real_ack = ack && above_prio;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q        <= 1'b0;
      ack_valid_q  <= 1'b0;
      ack_vec_q    <= '0;
      ack_spur_q   <= 1'b0;
      isr_active_q <= 1'b0;
      isr_vec_q    <= '0;
    end else begin
      irq_q       <= eligible && !real_ack;
      ack_valid_q <= ack;
      if (ack) begin
        ack_vec_q  <= real_ack ? pend_vec : spur_vec;
        ack_spur_q <= !real_ack;
      end
      if (real_ack) begin
        isr_active_q <= 1'b1;
        isr_vec_q    <= pend_vec;
      end else if (eoi) begin
        isr_active_q <= 1'b0;
      end
    end
  end

  assert_irq_low_on_ack_R9: assert property (@(posedge clk) disable iff (rst)
    (ack_valid_q && !ack_spur_q) |-> !irq_q);

  assert_spur_keeps_isr_R10: assert property (@(posedge clk) disable iff (rst)
    (ack && !above_prio && !eoi) |=> ($stable(isr_active_q) && $stable(isr_vec_q)));

  assert_eoi_clears_R11: assert property (@(posedge clk) disable iff (rst)
    (eoi && !ack) |=> !isr_active_q);

  assert_ack_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    ack |=> ack_valid_q);
endmodule

// File: rtl/prio_gate.sv
module prio_gate
  import gate_pkg::*;
#(
  parameter int CRW = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mm_we,
  input  logic [1:0]     mm_sel,
  input  logic [7:0]     mm_wdata,
  input  logic           cr_we,
  input  logic [CRW-1:0] cr_wdata,
  output logic [CRW-1:0] cr_rdata,
  output logic           cr_fault,
  output logic [7:0]     prio_o,
  output logic [7:0]     spur_o,
  output logic           en_o,
  input  logic           pend_valid,
  input  logic [7:0]     pend_vec,
  input  logic           ack,
  input  logic           eoi,
  output logic           irq,
  output logic           ack_valid,
  output logic [7:0]     ack_vec,
  output logic           ack_spur,
  output logic           isr_active,
  output logic [7:0]     isr_vec
);
  logic above_prio, eligible;

  tpr_reg #(.CRW(CRW)) u_tpr (
    .clk(clk), .rst(rst),
    .mm_we(mm_we), .mm_sel(mm_sel), .mm_wdata(mm_wdata),
    .cr_we(cr_we), .cr_wdata(cr_wdata),
    .prio_q(prio_o), .spur_q(spur_o), .en_q(en_o),
    .fault_q(cr_fault), .cr_rdata(cr_rdata)
  );

  req_eval u_eval (
    .pend_valid(pend_valid),
    .pend_cls(pend_vec[VW-1:VW-CW]),
    .prio_cls(prio_o[VW-1:VW-CW]),
    .isr_active(isr_active),
    .isr_cls(isr_vec[VW-1:VW-CW]),
    .above_prio(above_prio),
    .eligible(eligible)
  );

  ack_unit u_ack (
    .clk(clk), .rst(rst),
    .ack(ack), .eoi(eoi),
    .above_prio(above_prio), .eligible(eligible),
    .pend_vec(pend_vec), .spur_vec(spur_o),
    .irq_q(irq), .ack_valid_q(ack_valid), .ack_vec_q(ack_vec),
    .ack_spur_q(ack_spur), .isr_active_q(isr_active), .isr_vec_q(isr_vec)
  );

  assert_direct_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (mm_we && mm_sel == SEL_PRIO && cr_we) |=> (prio_o == $past(mm_wdata)));
endmodule

// File: tb/sim_prio_gate.sv
module sim_prio_gate;
  localparam int CRW = 64;

  logic           clk = 1'b0;
  logic           rst;
  logic           mm_we;
  logic [1:0]     mm_sel;
  logic [7:0]     mm_wdata;
  logic           cr_we;
  logic [CRW-1:0] cr_wdata;
  logic [CRW-1:0] cr_rdata;
  logic           cr_fault;
  logic [7:0]     prio_o, spur_o;
  logic           en_o;
  logic           pend_valid;
  logic [7:0]     pend_vec;
  logic           ack, eoi;
  logic           irq, ack_valid, ack_spur, isr_active;
  logic [7:0]     ack_vec, isr_vec;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  prio_gate #(.CRW(CRW)) u0 (
    .clk(clk), .rst(rst),
    .mm_we(mm_we), .mm_sel(mm_sel), .mm_wdata(mm_wdata),
    .cr_we(cr_we), .cr_wdata(cr_wdata), .cr_rdata(cr_rdata), .cr_fault(cr_fault),
    .prio_o(prio_o), .spur_o(spur_o), .en_o(en_o),
    .pend_valid(pend_valid), .pend_vec(pend_vec), .ack(ack), .eoi(eoi),
    .irq(irq), .ack_valid(ack_valid), .ack_vec(ack_vec), .ack_spur(ack_spur),
    .isr_active(isr_active), .isr_vec(isr_vec)
  );

  // entry: {prio, pend_vec, expected irq / real ack}
  localparam int NV = 8;
  localparam logic [16:0] TBL [NV] = '{
    {8'h00, 8'h10, 1'b1},
    {8'h00, 8'h05, 1'b0},
    {8'h30, 8'h41, 1'b1},
    {8'h3F, 8'h3A, 1'b0},
    {8'h5C, 8'h61, 1'b1},
    {8'h7F, 8'h80, 1'b1},
    {8'hF0, 8'hFF, 1'b0},
    {8'hE0, 8'hF3, 1'b1}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic mm_write(input logic [1:0] sel, input logic [7:0] d);
    mm_we = 1'b1; mm_sel = sel; mm_wdata = d;
    tick();
    mm_we = 1'b0;
  endtask

  task automatic cr_write(input logic [CRW-1:0] d);
    cr_we = 1'b1; cr_wdata = d;
    tick();
    cr_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; mm_we = 0; mm_sel = 0; mm_wdata = 0; cr_we = 0; cr_wdata = 0;
    pend_valid = 0; pend_vec = 0; ack = 0; eoi = 0;
    tick(); tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1 prio", prio_o, 8'h00);
    chk("R1 spur", spur_o, 8'hFF);
    chk("R1 en", en_o, 1);
    chk("R1 irq", irq, 0);
    chk("R1 ack_valid", ack_valid, 0);
    chk("R1 fault", cr_fault, 0);
    chk("R1 isr", isr_active, 0);

    // R7 R8 R9 R11 vector table
    for (int i = 0; i < NV; i++) begin
      mm_write(2'd0, TBL[i][16:9]);
      pend_valid = 1'b1; pend_vec = TBL[i][8:1];
      tick();
      chk("R7 irq table", irq, TBL[i][0]);
      ack = 1'b1;
      tick();
      ack = 1'b0;
      chk("R8 ack_valid", ack_valid, 1);
      chk("R8 ack_vec", ack_vec, TBL[i][0] ? TBL[i][8:1] : 8'hFF);
      chk("R8 ack_spur", ack_spur, !TBL[i][0]);
      if (TBL[i][0]) chk("R9 irq low at ack", irq, 0);
      chk("R9 isr set", isr_active, TBL[i][0]);
      if (TBL[i][0]) chk("R9 isr_vec", isr_vec, TBL[i][8:1]);
      pend_valid = 1'b0; eoi = 1'b1;
      tick();
      eoi = 1'b0;
      chk("R8 strobe one cycle", ack_valid, 0);
      chk("R11 eoi clears", isr_active, 0);
    end

    // R2 spurious register and R3 control view
    mm_write(2'd1, 8'h27);
    chk("R2 spur write", spur_o, 8'h27);
    mm_write(2'd0, 8'h1B);
    cr_write(64'h6);
    chk("R3 cr write", prio_o, 8'h60);
    chk("R5 cr read", cr_rdata, 64'h6);

    // R4 reserved bits
    cr_we = 1'b1; cr_wdata = 64'h0000_0010_0000_0003;
    tick();
    cr_we = 1'b0;
    chk("R4 fault", cr_fault, 1);
    chk("R4 prio held", prio_o, 8'h60);
    tick();
    chk("R4 fault one cycle", cr_fault, 0);

    // R6 precedence
    mm_we = 1'b1; mm_sel = 2'd0; mm_wdata = 8'h9A; cr_we = 1'b1; cr_wdata = 64'h3;
    tick();
    mm_we = 1'b0; cr_we = 1'b0;
    chk("R6 direct wins", prio_o, 8'h9A);

    // R5 disabled
    mm_write(2'd2, 8'h00);
    chk("R2 enable write", en_o, 0);
    chk("R5 read disabled", cr_rdata, 64'h0);
    cr_write(64'h4);
    chk("R5 write ignored", prio_o, 8'h9A);
    mm_write(2'd2, 8'h01);
    chk("R5 read enabled", cr_rdata, 64'h9);

    // R8 R10 masked after request via control view
    mm_write(2'd0, 8'h20);
    pend_valid = 1'b1; pend_vec = 8'h55;
    tick();
    chk("R7 irq raised", irq, 1);
    cr_write(64'h5);
    ack = 1'b1;
    tick();
    ack = 1'b0;
    chk("R8 late mask spur", ack_vec, 8'h27);
    chk("R8 late mask flag", ack_spur, 1);
    chk("R10 isr untouched", isr_active, 0);

    // R7 R10 in-service blocking then spurious keeps isr
    mm_write(2'd0, 8'h10);
    pend_vec = 8'h44;
    tick();
    ack = 1'b1;
    tick();
    ack = 1'b0;
    chk("R9 isr_vec", isr_vec, 8'h44);
    pend_vec = 8'h4E;
    tick(); tick();
    chk("R7 blocked by isr class", irq, 0);
    pend_vec = 8'h71;
    tick(); tick();
    chk("R7 above isr class", irq, 1);
    mm_write(2'd0, 8'hA0);
    ack = 1'b1;
    tick();
    ack = 1'b0;
    chk("R10 spur ack flag", ack_spur, 1);
    chk("R10 isr active kept", isr_active, 1);
    chk("R10 isr_vec kept", isr_vec, 8'h44);

    // R1 reset again
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R1 reset prio", prio_o, 8'h00);
    chk("R1 reset spur", spur_o, 8'hFF);
    chk("R1 reset isr", isr_active, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule